// File: doc/BRIEF.md
# UART Receive Buffer with Line Status

This block sits between a serial deframer and a host bus. The deframer hands over each finished character as one write strobe. The strobe carries eight data bits and three per-character flags: parity error, framing error and break. The block holds the characters for the host and keeps a live eight-bit line-status word. From that word it derives two interrupt requests, one for receive data and one for line errors.

There are two modes, selected by `fifo_en_i`. With the mode bit low, the block behaves as a single holding register. A new character that arrives before the old one is read replaces it and records an overrun. With the mode bit high, characters go into a 16-entry queue. Each entry stores its own flags, and the status word shows the flags of the entry at the head. An aggregate bit stays set while any held entry carries a flag. The overrun flag clears when the host reads the status word. The per-character flags leave as their characters are read out.

Top module: `rx_line_status`

## Requirements
- R1: Status bit 0 (data ready) is 1 while at least one unread character is held and 0 once every held character has been read. A write that is not dropped by a mode change always leaves bit 0 set on the next cycle.
- R2: Status bits 2 (parity), 3 (framing) and 4 (break) show the flags stored with the character at the head. The entry flag order is {break, framing, parity, data[7:0]}. All three bits are 0 when nothing is held.
- R3: Status bit 7 is 1 while any held character carries a parity, framing or break flag, and falls only when the last such character has been read out.
- R4: In queue mode (`fifo_en_i`=1), a write that arrives with 16 characters held and no buffer read in the same cycle is discarded and sets status bit 1 (overrun). A write into a full queue together with a buffer read is accepted.
- R5: In holding-register mode (`fifo_en_i`=0), at most one character is held. A write that arrives while it is occupied and not being read replaces it and sets status bit 1.
- R6: A status read (`rd_stat_i`) clears bit 1 on the next cycle. If an overrun occurs in the same cycle as the status read, bit 1 stays set. Reading characters never clears bit 1.
- R7: Status bit 5 mirrors `tx_hold_empty_i` and bit 6 mirrors `tx_empty_i`. After reset the status word is 0x60 when both transmitter inputs are high, and `rx_data_o` is 0.
- R8: `irq_line_o` is 1 exactly when `ie_line_i` is 1 and any of status bits 1 to 4 is set.
- R9: `irq_rx_data_o` is 1 exactly when `ie_rx_data_i` is 1 and status bit 0 is set.
- R10: A buffer read (`rd_buf_i`) while data is held removes the head character and puts it on `rx_data_o` from the next cycle on. A buffer read with nothing held changes neither `rx_data_o` nor any status bit.
- R11: In any cycle where `fifo_en_i` differs from its value in the previous cycle, all held characters are discarded and that cycle's write and buffer-read strobes are ignored. The overrun bit keeps its value apart from R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 selects queue mode, 0 selects holding-register mode |
| wr_i | input | 1 | Character write strobe from the deframer |
| wr_data_i | input | 8 | Received character |
| wr_par_err_i | input | 1 | Parity error flag of the character |
| wr_frm_err_i | input | 1 | Framing error flag of the character |
| wr_brk_i | input | 1 | Break flag of the character |
| rd_buf_i | input | 1 | Host read strobe for the receive buffer |
| rd_stat_i | input | 1 | Host read strobe for the status word |
| ie_rx_data_i | input | 1 | Receive-data interrupt enable |
| ie_line_i | input | 1 | Line-status interrupt enable |
| tx_hold_empty_i | input | 1 | Transmit holding stage empty |
| tx_empty_i | input | 1 | Transmitter fully empty |
| rx_data_o | output | 8 | Last character read out |
| stat_o | output | 8 | Line-status word |
| irq_rx_data_o | output | 1 | Receive-data interrupt request |
| irq_line_o | output | 1 | Line-status interrupt request |

## Verification
The hardest states to reach from the ports are the edge cases of the queue. One is a write into a full queue in the same cycle as a buffer read, which must be accepted. Another is an overrun that coincides with a status read, which must keep the overrun bit. A third is the aggregate error bit, which must fall only when the last flagged entry leaves while clean entries sit ahead of it or behind it. The directed part of the bench fills all 16 entries, with flags on scattered entries, and then drives each of these coincidences explicitly. After that a long random run with write-heavy and read-heavy phases, occasional mode flips and status reads keeps pushing the queue through full, empty and mode-change boundaries. A queue-based model is compared against the design on every cycle throughout.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int unsigned RXS_DATA_W = 8;
  localparam int unsigned RXS_STAT_W = 8;

  // status bit positions
  localparam int unsigned ST_DR   = 0;
  localparam int unsigned ST_OE   = 1;
  localparam int unsigned ST_PAR  = 2;
  localparam int unsigned ST_FRM  = 3;
  localparam int unsigned ST_BRK  = 4;
  localparam int unsigned ST_THE  = 5;
  localparam int unsigned ST_TEMT = 6;
  localparam int unsigned ST_FERR = 7;

  typedef struct packed {
    logic                  brk;
    logic                  frm;
    logic                  par;
    logic [RXS_DATA_W-1:0] data;
  } rx_entry_t;

  function automatic logic entry_has_err(rx_entry_t e);
    return e.brk | e.frm | e.par;
  endfunction
endpackage

// File: rtl/rxs_store.sv
module rxs_store
  import rxs_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             replace_i,
  input  rx_entry_t        wr_entry_i,
  output rx_entry_t        head_o,
  output logic [CNT_W-1:0] count_o
);
  rx_entry_t        mem_q [DEPTH];
  logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  // storage has no reset; head is qualified by count
  always_ff @(posedge clk_i) begin
    if (!flush_i) begin
      if (push_i)         mem_q[wr_ptr_q] <= wr_entry_i;
      else if (replace_i) mem_q[rd_ptr_q] <= wr_entry_i;
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rxs_err_track.sv
module rxs_err_track #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic push_i,
  input  logic pop_i,
  input  logic replace_i,
  input  logic new_err_i,
  input  logic head_err_i,
  output logic any_err_o
);
  logic [CNT_W-1:0] err_cnt_q;
  logic             inc, dec_pop, dec_rep;

  assign inc     = (push_i | replace_i) & new_err_i;
  assign dec_pop = pop_i & head_err_i;
  assign dec_rep = replace_i & head_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_cnt_q <= '0;
    else if (flush_i) err_cnt_q <= '0;
    else              err_cnt_q <= err_cnt_q + CNT_W'(inc) - CNT_W'(dec_pop) - CNT_W'(dec_rep);
  end

  assign any_err_o = (err_cnt_q != '0);
endmodule

// File: rtl/rxs_status.sv
module rxs_status
  import rxs_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  ovf_evt_i,
  input  logic                  rd_stat_i,
  input  logic                  dr_i,
  input  rx_entry_t             head_i,
  input  logic                  any_err_i,
  input  logic                  tx_hold_empty_i,
  input  logic                  tx_empty_i,
  input  logic                  ie_rx_data_i,
  input  logic                  ie_line_i,
  output logic [RXS_STAT_W-1:0] stat_o,
  output logic                  irq_rx_data_o,
  output logic                  irq_line_o
);
  logic oe_q;

  // a new overrun beats a simultaneous status read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        oe_q <= 1'b0;
    else if (ovf_evt_i) oe_q <= 1'b1;
    else if (rd_stat_i) oe_q <= 1'b0;
  end

  always_comb begin
    stat_o          = '0;
    stat_o[ST_DR]   = dr_i;
    stat_o[ST_OE]   = oe_q;
    stat_o[ST_PAR]  = dr_i & head_i.par;
    stat_o[ST_FRM]  = dr_i & head_i.frm;
    stat_o[ST_BRK]  = dr_i & head_i.brk;
    stat_o[ST_THE]  = tx_hold_empty_i;
    stat_o[ST_TEMT] = tx_empty_i;
    stat_o[ST_FERR] = any_err_i;
  end

  assign irq_rx_data_o = ie_rx_data_i & dr_i;
  assign irq_line_o    = ie_line_i & (oe_q | (dr_i & entry_has_err(head_i)));
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rxs_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  fifo_en_i,
  input  logic                  wr_i,
  input  logic [RXS_DATA_W-1:0] wr_data_i,
  input  logic                  wr_par_err_i,
  input  logic                  wr_frm_err_i,
  input  logic                  wr_brk_i,
  input  logic                  rd_buf_i,
  input  logic                  rd_stat_i,
  input  logic                  ie_rx_data_i,
  input  logic                  ie_line_i,
  input  logic                  tx_hold_empty_i,
  input  logic                  tx_empty_i,
  output logic [RXS_DATA_W-1:0] rx_data_o,
  output logic [RXS_STAT_W-1:0] stat_o,
  output logic                  irq_rx_data_o,
  output logic                  irq_line_o
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  rx_entry_t             wr_entry, head;
  logic [CNT_W-1:0]      count;
  logic                  fifo_en_q, flush, empty, full, room;
  logic                  do_pop, push, ovf, replace, any_err;
  logic [RXS_DATA_W-1:0] rx_data_q;

  assign wr_entry = '{brk: wr_brk_i, frm: wr_frm_err_i, par: wr_par_err_i, data: wr_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fifo_en_q <= 1'b0;
    else         fifo_en_q <= fifo_en_i;
  end

  assign flush   = fifo_en_i ^ fifo_en_q;
  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign room    = fifo_en_i ? !full : empty;
  assign do_pop  = rd_buf_i & !empty & !flush;
  assign push    = wr_i & !flush & (room | do_pop);
  assign ovf     = wr_i & !flush & !room & !do_pop;
  assign replace = ovf & !fifo_en_i;

  rxs_store #(.DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .push_i     (push),
    .pop_i      (do_pop),
    .replace_i  (replace),
    .wr_entry_i (wr_entry),
    .head_o     (head),
    .count_o    (count)
  );

  rxs_err_track #(.DEPTH(DEPTH)) u_err (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (flush),
    .push_i     (push),
    .pop_i      (do_pop),
    .replace_i  (replace),
    .new_err_i  (entry_has_err(wr_entry)),
    .head_err_i (entry_has_err(head)),
    .any_err_o  (any_err)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rx_data_q <= '0;
    else if (do_pop) rx_data_q <= head.data;
  end
  assign rx_data_o = rx_data_q;

  rxs_status u_status (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .ovf_evt_i       (ovf),
    .rd_stat_i       (rd_stat_i),
    .dr_i            (!empty),
    .head_i          (head),
    .any_err_i       (any_err),
    .tx_hold_empty_i (tx_hold_empty_i),
    .tx_empty_i      (tx_empty_i),
    .ie_rx_data_i    (ie_rx_data_i),
    .ie_line_i       (ie_line_i),
    .stat_o          (stat_o),
    .irq_rx_data_o   (irq_rx_data_o),
    .irq_line_o      (irq_line_o)
  );
endmodule

// File: rtl/rxs_checker.sv
module rxs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       rd_buf_i,
  input logic       rd_stat_i,
  input logic       ie_rx_data_i,
  input logic       ie_line_i,
  input logic [7:0] rx_data_o,
  input logic [4:0] stat_lo_i,
  input logic       ferr_i,
  input logic       irq_rx_data_o,
  input logic       irq_line_o,
  input logic       flush_i,
  input logic       ovf_i
);
  AST_DR_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !flush_i |=> stat_lo_i[0]); // R1
  AST_NO_FLAGS_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_lo_i[0] |-> (stat_lo_i[4:2] == 3'b000) && !ferr_i); // R2
  AST_HEAD_IN_AGG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_lo_i[4:2] != 3'b000) |-> ferr_i); // R3
  AST_OE_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_i |=> stat_lo_i[1]); // R4
  AST_OE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_stat_i && !ovf_i |=> !stat_lo_i[1]); // R6
  AST_IRQ_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_line_o |-> ie_line_i && (stat_lo_i[4:1] != 4'b0000)); // R8
  AST_IRQ_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_rx_data_o |-> ie_rx_data_i && stat_lo_i[0]); // R9
  AST_EMPTY_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_buf_i && !stat_lo_i[0] |=> $stable(rx_data_o)); // R10
endmodule

bind rx_line_status rxs_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_i          (wr_i),
  .rd_buf_i      (rd_buf_i),
  .rd_stat_i     (rd_stat_i),
  .ie_rx_data_i  (ie_rx_data_i),
  .ie_line_i     (ie_line_i),
  .rx_data_o     (rx_data_o),
  .stat_lo_i     (stat_o[4:0]),
  .ferr_i        (stat_o[7]),
  .irq_rx_data_o (irq_rx_data_o),
  .irq_line_o    (irq_line_o),
  .flush_i       (flush),
  .ovf_i         (ovf)
);

// File: tb/rx_line_status_bench.sv
`timescale 1ns/1ps
module rx_line_status_bench;
  localparam int DEPTH = 16;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fifo_en_i = 1'b0, wr_i = 1'b0, rd_buf_i = 1'b0, rd_stat_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       wr_par_err_i = 1'b0, wr_frm_err_i = 1'b0, wr_brk_i = 1'b0;
  logic       ie_rx_data_i = 1'b0, ie_line_i = 1'b0;
  logic       tx_hold_empty_i = 1'b1, tx_empty_i = 1'b1;
  logic [7:0] rx_data_o, stat_o;
  logic       irq_rx_data_o, irq_line_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  rx_line_status #(.DEPTH(DEPTH)) u_rx_line_status (.*);

  // reference model: entry = {brk, frm, par, data}
  logic [10:0] m_q[$];
  logic        m_oe, m_fen_q;
  logic [7:0]  m_last;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q.delete(); m_oe = 0; m_fen_q = 0; m_last = 0;
    end else begin
      logic flush, pop, room, ovf;
      flush = (fifo_en_i != m_fen_q);
      m_fen_q = fifo_en_i;
      ovf = 0;
      if (flush) m_q.delete();
      else begin
        pop  = rd_buf_i && (m_q.size() > 0);
        room = fifo_en_i ? (m_q.size() < DEPTH) : (m_q.size() == 0);
        ovf  = wr_i && !room && !pop;
        if (pop) begin m_last = m_q[0][7:0]; void'(m_q.pop_front()); end
        if (wr_i) begin
          if (room || pop) m_q.push_back({wr_brk_i, wr_frm_err_i, wr_par_err_i, wr_data_i});
          else if (!fifo_en_i) m_q[0] = {wr_brk_i, wr_frm_err_i, wr_par_err_i, wr_data_i};
        end
      end
      if (ovf) m_oe = 1;
      else if (rd_stat_i) m_oe = 0;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic dr, ferr;
    logic [2:0] hf;
    dr = (m_q.size() != 0);
    hf = dr ? m_q[0][10:8] : 3'b000;
    ferr = 0;
    foreach (m_q[i]) if (m_q[i][10:8] != 0) ferr = 1;
    check("R1", {7'b0, stat_o[0]}, {7'b0, dr});
    check("R2", {5'b0, stat_o[4:2]}, {5'b0, hf});
    check("R3", {7'b0, stat_o[7]}, {7'b0, ferr});
    check("R6", {7'b0, stat_o[1]}, {7'b0, m_oe});
    check("R7", {6'b0, stat_o[6:5]}, {6'b0, tx_empty_i, tx_hold_empty_i});
    check("R8", {7'b0, irq_line_o}, {7'b0, ie_line_i && (m_oe || hf != 0)});
    check("R9", {7'b0, irq_rx_data_o}, {7'b0, ie_rx_data_i && dr});
    check("R10", rx_data_o, m_last);
  endtask

  task automatic step(logic w, logic [10:0] e, logic rb, logic rs);
    wr_i = w; {wr_brk_i, wr_frm_err_i, wr_par_err_i, wr_data_i} = e;
    rd_buf_i = rb; rd_stat_i = rs;
    @(negedge clk_i);
    compare();
    wr_i = 0; rd_buf_i = 0; rd_stat_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk_i);
    check("R7", stat_o, 8'h60);
    check("R10", rx_data_o, 8'h00);
    rst_ni = 1;
    @(negedge clk_i);
    fifo_en_i = 1;
    step(0, 0, 0, 0);            // mode-change cycle
    ie_rx_data_i = 1; ie_line_i = 1;

    // basic traffic, parity flag on the middle character
    step(1, {3'b000, 8'h11}, 0, 0);
    check("R9", {7'b0, irq_rx_data_o}, 8'h01);
    step(1, {3'b001, 8'h22}, 0, 0);
    step(1, {3'b000, 8'h33}, 0, 0);
    check("R3", {7'b0, stat_o[7]}, 8'h01);
    step(0, 0, 1, 0);
    check("R2", {5'b0, stat_o[4:2]}, 8'h01);
    check("R8", {7'b0, irq_line_o}, 8'h01);
    step(0, 0, 1, 0);
    check("R3", {7'b0, stat_o[7]}, 8'h00);
    step(0, 0, 1, 0);
    check("R1", {7'b0, stat_o[0]}, 8'h00);

    // fill to capacity, framing flag on every fifth
    for (int i = 0; i < DEPTH; i++) step(1, {(i % 5 == 0) ? 3'b010 : 3'b000, 8'(i + 8'h40)}, 0, 0);
    step(1, {3'b000, 8'hEE}, 0, 0);
    check("R4", {7'b0, stat_o[1]}, 8'h01);
    step(1, {3'b100, 8'hDD}, 1, 0);  // full + read: accepted
    for (int i = 0; i < DEPTH + 2; i++) begin
      step(0, 0, 1, 0);
      check("R4", {7'b0, rx_data_o == 8'hEE}, 8'h00);
    end
    check("R10", rx_data_o, 8'hDD);
    check("R6", {7'b0, stat_o[1]}, 8'h01);
    step(0, 0, 0, 1);
    check("R6", {7'b0, stat_o[1]}, 8'h00);

    // overrun coinciding with a status read
    for (int i = 0; i < DEPTH; i++) step(1, {3'b000, 8'(i)}, 0, 0);
    step(1, {3'b000, 8'hEE}, 0, 1);
    check("R6", {7'b0, stat_o[1]}, 8'h01);
    for (int i = 0; i < DEPTH; i++) step(0, 0, 1, 0);
    held = rx_data_o;
    step(0, 0, 1, 0);
    step(0, 0, 1, 0);
    check("R10", rx_data_o, held);
    check("R10", stat_o & 8'h9D, 8'h00);
    step(0, 0, 0, 1);

    // holding-register mode
    fifo_en_i = 0;
    step(0, 0, 0, 0);
    step(1, {3'b000, 8'hA1}, 0, 0);
    step(1, {3'b010, 8'hA2}, 0, 0);
    check("R5", {7'b0, stat_o[1]}, 8'h01);
    check("R5", {5'b0, stat_o[4:2]}, 8'h02);
    step(0, 0, 1, 0);
    check("R5", rx_data_o, 8'hA2);
    check("R1", {7'b0, stat_o[0]}, 8'h00);

    // mode change discards held data and that cycle's strobes
    step(1, {3'b000, 8'hB1}, 0, 1);
    fifo_en_i = 1;
    step(1, {3'b000, 8'hB2}, 1, 0);
    check("R11", {7'b0, stat_o[0]}, 8'h00);
    check("R11", rx_data_o, 8'hA2);

    // random phases
    for (int c = 0; c < 6000; c++) begin
      int wp;
      wp = ((c / 300) % 2 == 0) ? 75 : 30;
      if ($urandom_range(0, 199) == 0) fifo_en_i = ~fifo_en_i;
      if ($urandom_range(0, 15) == 0) begin
        tx_hold_empty_i = 1'($urandom); tx_empty_i = 1'($urandom);
        ie_rx_data_i = 1'($urandom); ie_line_i = 1'($urandom);
      end
      step($urandom_range(0, 99) < wp,
           {($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000, 8'($urandom)},
           $urandom_range(0, 99) < (100 - wp),
           $urandom_range(0, 19) == 0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule